// File: doc/BRIEF.md
# Multi-Shot Capture Sequencer

This block sequences sample capture for a multi-channel ADC path. Software programs a pre-trigger sample count, a post-trigger sample count, a decimation factor and a number of shots through a small write port, then issues a start command. For each shot the sequencer first fills the pre-trigger count with kept samples, then waits for a trigger while still recording, then records the post-trigger count. After the last shot it returns to idle and raises an end-of-acquisition pulse.

Kept samples are packed two per channel into 32-bit words, and each finished word is presented to sample memory with a write strobe and a byte address that advances by four and wraps around the address space, so memory is used as a ring. The state, the live shot down-counter, the per-shot sample counter and the byte position of the last stored sample are readable through a select-driven read port. Trigger qualification, memory timing and the host bus protocol sit outside this block.

Top module: `shot_seq_top`

## Requirements
- R1: A write to register select 0 carries a command in bits [7:0]: 1 starts an acquisition (only from Idle; ignored in any other state), 2 stops, 3 is a software trigger; every other value leaves the block unchanged.
- R2: A stop command puts the state to Idle on the next clock edge from any state and raises no end-of-acquisition pulse.
- R3: Read select 0 returns the state in bits [2:0]: Idle=0, Pre-trigger Count=1, Wait Trigger=2, Wait End of Shot=3, Decrement Shot Count=4.
- R4: The sample counter (read select 5) clears on start and on each new shot, counts kept samples up to the pre-trigger count (select 1), holds while waiting for a trigger, then counts on until pre-trigger plus post-trigger (select 2); reaching each limit moves the state on at the next edge.
- R5: Writes to select 4 set the shot count from bits [15:0]; reading select 4 returns the live shot down-counter in [31:16] and the programmed count in [15:0]; start loads the down-counter (a count of 0 acts as 1) and each pass through Decrement Shot Count lowers it by one.
- R6: The decimation factor (select 3, bits [15:0]) resets to 1; after start the first valid sample is kept and then every factor-th valid sample; a factor of 0 acts as 1.
- R7: The trigger interrupt is a one-cycle pulse in the first cycle of Wait End of Shot; the end interrupt is a one-cycle pulse in the first Idle cycle after the last shot's Decrement Shot Count.
- R8: Kept samples are recorded while counting in Pre-trigger Count, in all of Wait Trigger and while counting in Wait End of Shot; every second recorded sample produces a one-cycle write with channel c's word at data bits [32c+31:32c] holding the later sample in its upper half and the earlier one in its lower half; byte addresses start at 0 after start, step by 4 and wrap modulo 2^ADDR_W.
- R9: Decrement Shot Count lasts one cycle, then goes to Pre-trigger Count with the sample counter at 0 while shots remain, or to Idle after the last shot.
- R10: A trigger (input or software) seen in Pre-trigger Count has no effect; only a trigger in Wait Trigger advances the machine.
- R11: Read select 6 returns the byte address of the last stored sample of channel 0, equal to the last word address plus 3 (form 4n-1); start clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for writes |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 3 | Register select for readback |
| rd_data_o | output | 32 | Readback data (combinational) |
| trig_i | input | 1 | Qualified hardware trigger strobe |
| smp_valid_i | input | 1 | Sample valid strobe |
| smp_data_i | input | NCH*16 | Current sample of every channel, channel c at [16c+15:16c] |
| mem_we_o | output | 1 | Memory word write strobe |
| mem_addr_o | output | ADDR_W | Byte address of the written word |
| mem_data_o | output | NCH*32 | Packed word of every channel |
| state_o | output | 3 | Current state code |
| irq_trig_o | output | 1 | Trigger interrupt pulse |
| irq_end_o | output | 1 | End-of-acquisition interrupt pulse |

## Verification
The bench builds the block with two channels, an 8-bit count width and a 6-bit address, so a single 40-sample shot spills past the sixteen-word ring and the address wrap and last-position arithmetic are exercised in a short run. Narrow counters also keep multi-shot runs, decimation by three and stop commands in every phase cheap, while the scoreboard compares every packed word and address against samples the driver predicted.

// File: rtl/shot_seq_pkg.sv
package shot_seq_pkg;

  localparam int DEC_W  = 16;
  localparam int SHOT_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_WAIT = 3'd2,
    ST_POST = 3'd3,
    ST_DEC  = 3'd4
  } seq_state_t;

  localparam logic [7:0] CMD_START  = 8'd1;
  localparam logic [7:0] CMD_STOP   = 8'd2;
  localparam logic [7:0] CMD_SWTRIG = 8'd3;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_PRE   = 3'd1;
  localparam logic [2:0] SEL_POST  = 3'd2;
  localparam logic [2:0] SEL_DECIM = 3'd3;
  localparam logic [2:0] SEL_SHOTS = 3'd4;
  localparam logic [2:0] SEL_SCNT  = 3'd5;
  localparam logic [2:0] SEL_LAST  = 3'd6;

  // A zero factor behaves like no decimation.
  function automatic logic [DEC_W-1:0] eff_factor(input logic [DEC_W-1:0] f);
    return (f == '0) ? DEC_W'(1) : f;
  endfunction

  // A zero shot count still runs one shot.
  function automatic logic [SHOT_W-1:0] eff_shots(input logic [SHOT_W-1:0] n);
    return (n == '0) ? SHOT_W'(1) : n;
  endfunction

  // Next decimation phase, wrapping at the effective factor.
  function automatic logic [DEC_W-1:0] next_phase(input logic [DEC_W-1:0] ph,
                                                  input logic [DEC_W-1:0] f);
    return (ph >= eff_factor(f) - DEC_W'(1)) ? '0 : ph + DEC_W'(1);
  endfunction

endpackage

// File: rtl/seq_decim.sv
module seq_decim
  import shot_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             valid_i,
  input  logic [DEC_W-1:0] factor_i,
  output logic             keep_o
);

  logic [DEC_W-1:0] phase_q;

  assign keep_o = valid_i && (phase_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart_i) begin
      phase_q <= '0;
    end else if (valid_i) begin
      phase_q <= next_phase(phase_q, factor_i);
    end
  end

  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(restart_i) && valid_i) |-> keep_o); // R6

endmodule

// File: rtl/seq_pack.sv
module seq_pack #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart_i,
  input  logic                rec_i,
  input  logic [NCH*16-1:0]   data_i,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [NCH*32-1:0]   mem_data_o,
  output logic [ADDR_W-1:0]   last_pos_o
);

  localparam int WIX_W = ADDR_W - 2;

  logic             half_q;
  logic [WIX_W-1:0] wix_q;
  wire  [NCH*32-1:0] word_bus;
  logic             word_done;

  assign word_done = rec_i && half_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    logic [15:0] lo_q;
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q   <= '0;
        word_q <= '0;
      end else if (rec_i && !half_q) begin
        lo_q <= data_i[ch*16 +: 16];
      end else if (word_done) begin
        word_q <= {data_i[ch*16 +: 16], lo_q};
      end
    end
    assign word_bus[ch*32 +: 32] = word_q;
  end

  assign mem_data_o = word_bus;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q     <= 1'b0;
      wix_q      <= '0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      last_pos_o <= '0;
    end else if (restart_i) begin
      half_q     <= 1'b0;
      wix_q      <= '0;
      mem_we_o   <= 1'b0;
      last_pos_o <= '0;
    end else begin
      mem_we_o <= word_done;
      if (rec_i) half_q <= !half_q;
      if (word_done) begin
        mem_addr_o <= {wix_q, 2'b00};
        last_pos_o <= {wix_q, 2'b11};
        wix_q      <= wix_q + WIX_W'(1);
      end
    end
  end

  AST_WE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o); // R8

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import shot_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt_i,
  input  logic              stop_evt_i,
  input  logic              trig_evt_i,
  input  logic              keep_i,
  input  logic [CNT_W-1:0]  pre_i,
  input  logic [CNT_W-1:0]  post_i,
  input  logic [SHOT_W-1:0] shots_i,
  output seq_state_t        state_o,
  output logic [CNT_W:0]    smp_cnt_o,
  output logic [SHOT_W-1:0] shot_left_o,
  output logic              launch_o,
  output logic              rec_o,
  output logic              irq_trig_o,
  output logic              irq_end_o
);

  localparam int SC_W = CNT_W + 1;

  seq_state_t      st;
  logic [SC_W-1:0] pre_x;
  logic [SC_W-1:0] total_x;
  logic            pre_done;
  logic            post_done;
  logic            last_shot;

  assign pre_x     = {1'b0, pre_i};
  assign total_x   = pre_x + {1'b0, post_i};
  assign pre_done  = (smp_cnt_o >= pre_x);
  assign post_done = (smp_cnt_o >= total_x);
  assign last_shot = (shot_left_o <= SHOT_W'(1));
  assign state_o   = st;
  assign launch_o  = start_evt_i && (st == ST_IDLE) && !stop_evt_i;

  assign rec_o = keep_i && !stop_evt_i &&
                 (((st == ST_PRE) && !pre_done) ||
                  (st == ST_WAIT) ||
                  ((st == ST_POST) && !post_done));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      smp_cnt_o   <= '0;
      shot_left_o <= '0;
      irq_trig_o  <= 1'b0;
      irq_end_o   <= 1'b0;
    end else begin
      irq_trig_o <= 1'b0;
      irq_end_o  <= 1'b0;
      if (stop_evt_i) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE: begin
            if (start_evt_i) begin
              st          <= ST_PRE;
              smp_cnt_o   <= '0;
              shot_left_o <= eff_shots(shots_i);
            end
          end
          ST_PRE: begin
            if (pre_done)    st <= ST_WAIT;
            else if (keep_i) smp_cnt_o <= smp_cnt_o + SC_W'(1);
          end
          ST_WAIT: begin
            if (trig_evt_i) begin
              st         <= ST_POST;
              irq_trig_o <= 1'b1;
            end
          end
          ST_POST: begin
            if (post_done)   st <= ST_DEC;
            else if (keep_i) smp_cnt_o <= smp_cnt_o + SC_W'(1);
          end
          ST_DEC: begin
            shot_left_o <= shot_left_o - SHOT_W'(1);
            if (last_shot) begin
              st        <= ST_IDLE;
              irq_end_o <= 1'b1;
            end else begin
              st        <= ST_PRE;
              smp_cnt_o <= '0;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt_i |=> (st == ST_IDLE)); // R2

  AST_DEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEC) |=> (st == ST_PRE || st == ST_IDLE)); // R9

  AST_PRE_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRE) |=> (st != ST_POST)); // R10

  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_trig_o |-> (st == ST_POST && $past(st) == ST_WAIT)); // R7

  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end_o |-> (st == ST_IDLE && $past(st) == ST_DEC)); // R7

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !stop_evt_i && !trig_evt_i) |=> $stable(smp_cnt_o)); // R4

  AST_SHOT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> (shot_left_o <= $past(shot_left_o))); // R5

endmodule

// File: rtl/shot_seq_top.sv
module shot_seq_top
  import shot_seq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_sel_i,
  input  logic [31:0]         wr_data_i,
  input  logic [2:0]          rd_sel_i,
  output logic [31:0]         rd_data_o,
  input  logic                trig_i,
  input  logic                smp_valid_i,
  input  logic [NCH*16-1:0]   smp_data_i,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [NCH*32-1:0]   mem_data_o,
  output logic [2:0]          state_o,
  output logic                irq_trig_o,
  output logic                irq_end_o
);

  logic [CNT_W-1:0]  pre_q;
  logic [CNT_W-1:0]  post_q;
  logic [DEC_W-1:0]  decim_q;
  logic [SHOT_W-1:0] shots_q;

  logic              ctrl_wr;
  logic              start_evt;
  logic              stop_evt;
  logic              swtrig_evt;
  logic              trig_evt;
  logic              keep;
  logic              launch;
  logic              rec;
  seq_state_t        st;
  logic [CNT_W:0]    smp_cnt;
  logic [SHOT_W-1:0] shot_left;
  logic [ADDR_W-1:0] last_pos;

  assign ctrl_wr    = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign start_evt  = ctrl_wr && (wr_data_i[7:0] == CMD_START);
  assign stop_evt   = ctrl_wr && (wr_data_i[7:0] == CMD_STOP);
  assign swtrig_evt = ctrl_wr && (wr_data_i[7:0] == CMD_SWTRIG);
  assign trig_evt   = trig_i || swtrig_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      post_q  <= '0;
      decim_q <= DEC_W'(1);
      shots_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        SEL_PRE:   pre_q   <= wr_data_i[CNT_W-1:0];
        SEL_POST:  post_q  <= wr_data_i[CNT_W-1:0];
        SEL_DECIM: decim_q <= wr_data_i[DEC_W-1:0];
        SEL_SHOTS: shots_q <= wr_data_i[SHOT_W-1:0];
        default: ;
      endcase
    end
  end

  seq_decim u_decim (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (launch),
    .valid_i   (smp_valid_i),
    .factor_i  (decim_q),
    .keep_o    (keep)
  );

  seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt_i (start_evt),
    .stop_evt_i  (stop_evt),
    .trig_evt_i  (trig_evt),
    .keep_i      (keep),
    .pre_i       (pre_q),
    .post_i      (post_q),
    .shots_i     (shots_q),
    .state_o     (st),
    .smp_cnt_o   (smp_cnt),
    .shot_left_o (shot_left),
    .launch_o    (launch),
    .rec_o       (rec),
    .irq_trig_o  (irq_trig_o),
    .irq_end_o   (irq_end_o)
  );

  seq_pack #(.NCH(NCH), .ADDR_W(ADDR_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (launch),
    .rec_i      (rec),
    .data_i     (smp_data_i),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_o (mem_data_o),
    .last_pos_o (last_pos)
  );

  assign state_o = st;

  always_comb begin
    unique case (rd_sel_i)
      SEL_CTRL:  rd_data_o = {29'd0, st};
      SEL_PRE:   rd_data_o = 32'(pre_q);
      SEL_POST:  rd_data_o = 32'(post_q);
      SEL_DECIM: rd_data_o = 32'(decim_q);
      SEL_SHOTS: rd_data_o = {shot_left, shots_q};
      SEL_SCNT:  rd_data_o = 32'(smp_cnt);
      SEL_LAST:  rd_data_o = 32'(last_pos);
      default:   rd_data_o = '0;
    endcase
  end

  AST_LAST_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (last_pos != '0) |-> (last_pos[1:0] == 2'b11)); // R11

  AST_WRITE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ($past(st) != ST_IDLE && $past(st) != ST_DEC)); // R8

endmodule

// File: tb/shot_seq_top_test.sv
module shot_seq_top_test;

  localparam int NCH    = 2;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 6;
  localparam int RING   = (1 << ADDR_W) / 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                wr_en = 1'b0;
  logic [2:0]          wr_sel = '0;
  logic [31:0]         wr_data = '0;
  logic [2:0]          rd_sel = '0;
  logic [31:0]         rd_data;
  logic                trig = 1'b0;
  logic                smp_valid = 1'b0;
  logic [NCH*16-1:0]   smp_data = '0;
  logic                mem_we;
  logic [ADDR_W-1:0]   mem_addr;
  logic [NCH*32-1:0]   mem_data;
  logic [2:0]          state;
  logic                irq_trig;
  logic                irq_end;

  always #5 clk = !clk;

  shot_seq_top #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .trig_i(trig), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .state_o(state), .irq_trig_o(irq_trig), .irq_end_o(irq_end)
  );

  typedef struct packed {
    logic [ADDR_W-1:0] a;
    logic [NCH*32-1:0] d;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  int b_vidx, b_D, b_word, b_seq;
  bit b_half, b_rec;
  logic [15:0] b_lo [NCH];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic start_run(input int d);
    wr(3'd0, 32'd1);
    b_vidx = 0; b_D = (d == 0) ? 1 : d; b_word = 0; b_half = 0;
  endtask

  // Driver: sends one valid sample and pushes expected words (R8, R6).
  task automatic samp();
    logic [NCH*32-1:0] w;
    bit kept;
    @(negedge clk);
    smp_valid = 1'b1;
    for (int c = 0; c < NCH; c++) smp_data[c*16 +: 16] = 16'(c * 16'h1000) + 16'(b_seq & 12'hfff);
    kept = (b_vidx % b_D) == 0;
    b_vidx++;
    if (kept && b_rec) begin
      if (!b_half) begin
        for (int c = 0; c < NCH; c++) b_lo[c] = smp_data[c*16 +: 16];
      end else begin
        for (int c = 0; c < NCH; c++) w[c*32 +: 32] = {smp_data[c*16 +: 16], b_lo[c]};
        exp_q.push_back('{a: ADDR_W'((b_word % RING) * 4), d: w});
        b_word++;
      end
      b_half = !b_half;
    end
    b_seq++;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // Monitor: compares every memory write with the scoreboard (R8).
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected write", {26'd0, mem_addr}, 32'hffffffff);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R8 address", 32'(mem_addr), 32'(e.a));
        total++;
        if (mem_data !== e.d) begin
          bad++;
          $display("FAIL R8 data actual=0x%0h expected=0x%0h", mem_data, e.d);
        end
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    b_seq = 0; b_rec = 1; b_D = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd(3'd0, v); chk("R3 reset state", v, 32'd0);
    rd(3'd3, v); chk("R6 decimation resets to 1", v, 32'd1);
    rd(3'd4, v); chk("R5 shot register reset", v, 32'd0);
    chk("R7 irq idle after reset", {30'd0, irq_trig, irq_end}, 32'd0);

    // Unknown command has no effect
    wr(3'd0, 32'h0000_0005);
    rd(3'd0, v); chk("R1 unknown command ignored", v, 32'd0);
    chk("R8 no write after unknown command", 32'(mem_we), 32'd0);

    // Single shot P=3 Q=4
    wr(3'd1, 32'd3); wr(3'd2, 32'd4); wr(3'd4, 32'hABCD_0001);
    rd(3'd4, v); chk("R5 upper bits ignore writes", v, 32'h0000_0001);
    start_run(1);
    rd(3'd0, v); chk("R3 pre-trigger code", v, 32'd1);
    rd(3'd5, v); chk("R4 counter cleared on start", v, 32'd0);
    rd(3'd4, v); chk("R5 down-counter loaded", v, 32'h0001_0001);
    samp();
    @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
    rd(3'd0, v); chk("R10 trigger in pre-trigger ignored", v, 32'd1);
    chk("R10 no trigger pulse", 32'(irq_trig), 32'd0);
    samp(); samp();
    rd(3'd5, v); chk("R4 counted to pre", v, 32'd3);
    @(negedge clk);
    rd(3'd0, v); chk("R3 wait trigger code", v, 32'd2);
    wr(3'd0, 32'd1);
    rd(3'd0, v); chk("R1 start ignored when busy", v, 32'd2);
    samp(); samp();
    rd(3'd5, v); chk("R4 holds while waiting", v, 32'd3);
    @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
    rd(3'd0, v); chk("R3 wait end of shot code", v, 32'd3);
    chk("R7 trigger pulse high", 32'(irq_trig), 32'd1);
    @(negedge clk);
    chk("R7 trigger pulse one cycle", 32'(irq_trig), 32'd0);
    for (int i = 0; i < 4; i++) samp();
    rd(3'd5, v); chk("R4 counted to pre+post", v, 32'd7);
    @(negedge clk);
    rd(3'd0, v); chk("R9 decrement state code", v, 32'd4);
    @(negedge clk);
    rd(3'd0, v); chk("R9 idle after last shot", v, 32'd0);
    chk("R7 end pulse high", 32'(irq_end), 32'd1);
    rd(3'd6, v); chk("R11 last position", v, 32'd15);
    @(negedge clk);
    chk("R7 end pulse one cycle", 32'(irq_end), 32'd0);
    rd(3'd4, v); chk("R5 down-counter exhausted", v, 32'h0000_0001);

    // Three shots P=2 Q=2, software trigger
    wr(3'd1, 32'd2); wr(3'd2, 32'd2); wr(3'd4, 32'd3);
    start_run(1);
    rd(3'd6, v); chk("R11 cleared by start", v, 32'd0);
    for (int s = 0; s < 3; s++) begin
      rd(3'd4, v); chk("R5 live shots remaining", v, {16'(3 - s), 16'd3});
      samp(); samp();
      @(negedge clk);
      rd(3'd0, v); chk("R4 pre reached", v, 32'd2);
      wr(3'd0, 32'd3);
      rd(3'd0, v); chk("R1 software trigger", v, 32'd3);
      chk("R7 trigger pulse from software", 32'(irq_trig), 32'd1);
      samp(); samp();
      @(negedge clk);
      rd(3'd0, v); chk("R9 decrement", v, 32'd4);
      @(negedge clk);
      if (s < 2) begin
        rd(3'd0, v); chk("R9 back to pre-trigger", v, 32'd1);
        rd(3'd5, v); chk("R9 counter restarted", v, 32'd0);
        chk("R7 no end pulse mid run", 32'(irq_end), 32'd0);
      end else begin
        rd(3'd0, v); chk("R9 idle after three shots", v, 32'd0);
        chk("R7 end pulse after last shot", 32'(irq_end), 32'd1);
      end
    end
    rd(3'd6, v); chk("R11 last position multi-shot", v, 32'd23);

    // Decimation by 3, P=2 Q=2
    wr(3'd3, 32'd3); wr(3'd4, 32'd1);
    start_run(3);
    for (int i = 0; i < 4; i++) samp();
    rd(3'd5, v); chk("R6 two kept of four", v, 32'd2);
    @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
    for (int i = 0; i < 5; i++) samp();
    rd(3'd5, v); chk("R6 one more kept of five", v, 32'd3);
    samp();
    rd(3'd5, v); chk("R6 decimated post count", v, 32'd4);
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R6 run ends", v, 32'd0);

    // Ring wrap: P=20 Q=20, 20 words into a 16-word ring
    wr(3'd3, 32'd0); wr(3'd1, 32'd20); wr(3'd2, 32'd20);
    start_run(0);
    for (int i = 0; i < 20; i++) samp();
    @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
    for (int i = 0; i < 20; i++) samp();
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R6 zero factor acts as one", v, 32'd0);
    rd(3'd6, v); chk("R11 last position after wrap", v, 32'd15);

    // Stop during pre-trigger and during post-trigger
    wr(3'd1, 32'd5); wr(3'd2, 32'd5); wr(3'd4, 32'd2);
    start_run(1);
    samp();
    wr(3'd0, 32'd2);
    rd(3'd0, v); chk("R2 stop from pre-trigger", v, 32'd0);
    chk("R2 no end pulse on stop", 32'(irq_end), 32'd0);
    wr(3'd1, 32'd1);
    start_run(1);
    samp();
    @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
    samp();
    wr(3'd0, 32'd2);
    rd(3'd0, v); chk("R2 stop from post-trigger", v, 32'd0);
    @(negedge clk);
    chk("R2 still no end pulse", 32'(irq_end), 32'd0);
    repeat (4) @(negedge clk);
    chk("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule